// File: doc/BRIEF.md
# Valley-Switched Cycle Timer

This block is the cycle-level timing engine of a primary-side flyback controller that runs in discontinuous conduction. Every switching cycle it raises the drive to the power switch. It masks the current-sense comparators for a blanking window, then ends the on-phase when the peak-current comparator trips. It waits for the secondary to finish demagnetizing and strobes the feedback sampler at that point. It then starts the next cycle on a valley of the drain ringing.

A valley is taken to be a fixed, programmable delay (about a quarter ring period) after a falling zero-crossing edge of the auxiliary winding. Valleys that arrive before the programmed minimum period has elapsed are skipped. A hard floor keeps the period from ever being shorter than the maximum switching frequency allows. If the ringing has died out and no falling edge is seen for a timeout window, the next cycle starts without valley alignment.

At each valley or timeout turn-on, the block reports the demagnetization length and the full period of the cycle that just ended, as clock counts. An over-current comparator that trips outside blanking stops switching and latches a fault until the sequencer drops the enable.

Top module: `vsw_cycle_timer`

## Requirements
- R1: While `rst` is high, and after it is released with `en` low, `drv`, `blank`, `fb_strobe`, `oc_fault` and `meas_valid` are all 0.
- R2: When `en` is low, `drv` is 0 in that same cycle. A later rise of `en` starts a new cycle one clock later with `drv` high, and `meas_valid` stays 0 on that first rise.
- R3: `blank` is high for exactly the first LEB_CYC drive-high cycles of each on-phase and low at all other times. `pk_trip` and `oc_trip` have no effect while `blank` is high.
- R4: If `pk_trip` is first seen in drive-high cycle a (counting from 0), the drive stays high for max(a, LEB_CYC, MIN_ON_CYC)+1 cycles.
- R5: An `oc_trip` seen outside blanking drives `drv` low on the next cycle and sets `oc_fault`. Both hold regardless of the other inputs until `en` goes low, which clears `oc_fault` on the following cycle.
- R6: A `demag_end` pulse is accepted only in drive-low cycle d (from 0) with d+1 >= MIN_DEMAG_CYC. Earlier pulses are ignored. `fb_strobe` is high for one cycle, the cycle after acceptance.
- R7: After acceptance, if a falling edge of `zc` is first seen in drive-low cycle X, the drive rises in drive-low cycle X+2+`q_dly`, provided the period reaches the effective minimum.
- R8: A valley that would give a period shorter than the effective minimum is skipped, and the drive rises on the first later valley that satisfies it.
- R9: If no falling edge of `zc` is seen for ZC_TMO_CYC cycles after acceptance or after the last edge, the drive rises at that point, or later once the effective minimum period is reached.
- R10: The effective minimum period is the larger of `min_period` and PER_FLOOR_CYC clock cycles, measured from drive rise to drive rise.
- R11: On each rise that follows a valley or a timeout, `meas_valid` is high for that one cycle. `period_cnt` then equals the cycles from the previous rise, and `demag_cnt` equals the drive-low cycles up to and including the accepted `demag_end` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable from the power sequencer |
| min_period | input | PW | Requested minimum period in clock cycles |
| q_dly | input | QW | Cycles from a falling zero crossing to the valley |
| pk_trip | input | 1 | Peak-current comparator output |
| oc_trip | input | 1 | Over-current comparator output |
| demag_end | input | 1 | End-of-demagnetization detector pulse |
| zc | input | 1 | Auxiliary winding above-zero comparator |
| drv | output | 1 | Power switch drive |
| blank | output | 1 | Leading-edge blanking window |
| fb_strobe | output | 1 | Feedback sample strobe |
| oc_fault | output | 1 | Latched over-current fault |
| meas_valid | output | 1 | Cycle measurement valid |
| demag_cnt | output | PW | Demagnetization length of the last cycle |
| period_cnt | output | PW | Period of the last cycle |

## Verification
A wrong phase state shows up at the drive pin within one switching cycle, as an on-time, a low-time or a rise position that differs from the arithmetic prediction. A skipped or misplaced valley shifts the next rise by whole ring periods. The ring pattern, demag length, valley delay and minimum period are swept together, so each rise falls in a cycle that only one of valley, skip, timeout or floor explains. Counter errors appear on `period_cnt` and `demag_cnt` at the very next rise. A fault latch that leaks shows as a drive pulse while `oc_fault` is high.

// File: rtl/vsw_pkg.sv
package vsw_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_ON    = 3'd1,
        PH_DEMAG = 3'd2,
        PH_RING  = 3'd3,
        PH_FAULT = 3'd4
    } vsw_phase_e;

    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/vsw_ontime.sv
module vsw_ontime
    import vsw_pkg::*;
#(
    parameter int LEB_CYC    = 38,
    parameter int MIN_ON_CYC = 38
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic pk_trip,
    input  logic oc_trip,
    output logic blank,
    output logic end_ok,
    output logic oc_hit
);
    localparam int CAP = imax(LEB_CYC, MIN_ON_CYC);
    localparam int TW  = cnt_w(CAP);

    logic [TW-1:0] tcnt;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            tcnt <= '0;
        end else if (tcnt != TW'(CAP)) begin
            tcnt <= tcnt + 1'b1;
        end
    end

    always_comb begin
        blank  = active && (tcnt < TW'(LEB_CYC));
        end_ok = active && !blank && (tcnt >= TW'(MIN_ON_CYC)) && pk_trip;
        oc_hit = active && !blank && oc_trip;
    end

    // R3: a fresh on-phase always opens with the blanking window
    p_blank_opens_r3: assert property (@(posedge clk) disable iff (rst)
        (LEB_CYC > 0) && $rose(active) |-> blank);

endmodule

// File: rtl/vsw_valley.sv
module vsw_valley
    import vsw_pkg::*;
#(
    parameter int QW         = 8,
    parameter int ZC_TMO_CYC = 388
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm,
    input  logic          zc,
    input  logic [QW-1:0] q_dly,
    output logic          valley,
    output logic          dead
);
    localparam int WW = cnt_w(ZC_TMO_CYC);

    logic          zc_q;
    logic          qact;
    logic [QW-1:0] qcnt;
    logic [WW-1:0] wcnt;
    logic          fall;

    assign fall = arm && zc_q && !zc;

    always_ff @(posedge clk) begin
        if (rst) zc_q <= 1'b1;
        else     zc_q <= zc;
    end

    always_ff @(posedge clk) begin
        if (rst || !arm) begin
            qact <= 1'b0;
            qcnt <= '0;
            wcnt <= '0;
        end else if (fall) begin
            qact <= 1'b1;
            qcnt <= '0;
            wcnt <= '0;
        end else begin
            if (qact) begin
                if (qcnt == q_dly) qact <= 1'b0;
                else               qcnt <= qcnt + 1'b1;
            end
            if (wcnt != WW'(ZC_TMO_CYC)) wcnt <= wcnt + 1'b1;
        end
    end

    assign valley = arm && qact && (qcnt == q_dly);
    assign dead   = arm && (wcnt == WW'(ZC_TMO_CYC));

    // R9: once the ringing is declared gone it stays gone until a new edge or disarm
    p_dead_holds_r9: assert property (@(posedge clk) disable iff (rst)
        dead && arm && zc |=> dead || !arm);

endmodule

// File: rtl/vsw_cycle_timer.sv
module vsw_cycle_timer
    import vsw_pkg::*;
#(
    parameter int PW            = 16,
    parameter int QW            = 8,
    parameter int LEB_CYC       = 38,
    parameter int MIN_ON_CYC    = 38,
    parameter int MIN_DEMAG_CYC = 150,
    parameter int ZC_TMO_CYC    = 388,
    parameter int PER_FLOOR_CYC = 1563
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [PW-1:0] min_period,
    input  logic [QW-1:0] q_dly,
    input  logic          pk_trip,
    input  logic          oc_trip,
    input  logic          demag_end,
    input  logic          zc,
    output logic          drv,
    output logic          blank,
    output logic          fb_strobe,
    output logic          oc_fault,
    output logic          meas_valid,
    output logic [PW-1:0] demag_cnt,
    output logic [PW-1:0] period_cnt
);
    localparam logic [PW-1:0] FLOOR = PW'(PER_FLOOR_CYC);
    localparam logic [PW:0]   DMIN  = (PW+1)'(MIN_DEMAG_CYC);
    localparam logic [PW-1:0] CMAX  = '1;

    vsw_phase_e     ph;
    logic [PW-1:0]  pcnt, dcnt, dem_lat;
    logic [PW-1:0]  minp_eff;
    logic [PW:0]    pcnt_n, dcnt_n;
    logic           per_ok, dm_ok, on_end, oc_hit, valley, dead;

    vsw_ontime #(.LEB_CYC(LEB_CYC), .MIN_ON_CYC(MIN_ON_CYC)) u_ontime (
        .clk(clk), .rst(rst), .active(ph == PH_ON && en),
        .pk_trip(pk_trip), .oc_trip(oc_trip),
        .blank(blank), .end_ok(on_end), .oc_hit(oc_hit)
    );

    vsw_valley #(.QW(QW), .ZC_TMO_CYC(ZC_TMO_CYC)) u_valley (
        .clk(clk), .rst(rst), .arm(ph == PH_RING), .zc(zc), .q_dly(q_dly),
        .valley(valley), .dead(dead)
    );

    always_comb begin
        minp_eff = (min_period > FLOOR) ? min_period : FLOOR;
        pcnt_n   = {1'b0, pcnt} + 1'b1;
        dcnt_n   = {1'b0, dcnt} + 1'b1;
        per_ok   = pcnt_n >= {1'b0, minp_eff};
        dm_ok    = demag_end && (dcnt_n >= DMIN);
        drv      = en && (ph == PH_ON);
        oc_fault = (ph == PH_FAULT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph         <= PH_IDLE;
            pcnt       <= '0;
            dcnt       <= '0;
            dem_lat    <= '0;
            fb_strobe  <= 1'b0;
            meas_valid <= 1'b0;
            demag_cnt  <= '0;
            period_cnt <= '0;
        end else begin
            fb_strobe  <= 1'b0;
            meas_valid <= 1'b0;
            if (pcnt != CMAX) pcnt <= pcnt + 1'b1;
            if (ph != PH_DEMAG)    dcnt <= '0;
            else if (dcnt != CMAX) dcnt <= dcnt + 1'b1;
            if (!en) begin
                ph <= PH_IDLE;
            end else begin
                unique case (ph)
                    PH_IDLE: begin
                        ph   <= PH_ON;
                        pcnt <= '0;
                    end
                    PH_ON: begin
                        if (oc_hit)      ph <= PH_FAULT;
                        else if (on_end) ph <= PH_DEMAG;
                    end
                    PH_DEMAG: begin
                        if (dm_ok) begin
                            ph        <= PH_RING;
                            fb_strobe <= 1'b1;
                            dem_lat   <= dcnt_n[PW-1:0];
                        end
                    end
                    PH_RING: begin
                        if ((valley || dead) && per_ok) begin
                            ph         <= PH_ON;
                            meas_valid <= 1'b1;
                            period_cnt <= pcnt_n[PW-1:0];
                            demag_cnt  <= dem_lat;
                            pcnt       <= '0;
                        end
                    end
                    PH_FAULT: ph <= PH_FAULT;
                    default:  ph <= PH_IDLE;
                endcase
            end
        end
    end

    // R2: a dropped enable leaves the drive off on the following cycle too
    p_en_low_off_r2: assert property (@(posedge clk) disable iff (rst)
        !en |=> !drv || en);
    // R3: blanking only exists while the switch is driven
    p_blank_in_on_r3: assert property (@(posedge clk) disable iff (rst)
        blank |-> drv);
    // R4: an on-phase lasts more than one cycle unless the enable drops
    p_on_min_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(drv) |=> drv || !en);
    // R5: the fault latch keeps the drive off while enabled
    p_fault_hold_r5: assert property (@(posedge clk) disable iff (rst)
        oc_fault && en |=> oc_fault && !drv);
    // R6: the sample strobe is a single-cycle pulse
    p_strobe_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        fb_strobe |=> !fb_strobe);
    // R10: no reported period is below the hard floor
    p_period_floor_r10: assert property (@(posedge clk) disable iff (rst)
        meas_valid |-> period_cnt >= FLOOR);
    // R11: a measurement is reported together with a fresh drive rise
    p_meas_on_rise_r11: assert property (@(posedge clk) disable iff (rst)
        meas_valid && en |-> $rose(drv));

endmodule

// File: tb/vsw_cycle_timer_tb.sv
module vsw_cycle_timer_tb;
    localparam int PW = 16, QW = 4;
    localparam int LEB = 4, MON = 6, MDM = 6, TMO = 10, FLR = 20, H = 3;

    logic clk = 1'b0, rst = 1'b1, en = 1'b0;
    logic [PW-1:0] min_period = '0;
    logic [QW-1:0] q_dly = '0;
    logic pk_trip = 1'b0, oc_trip = 1'b0, demag_end = 1'b0, zc = 1'b1;
    logic drv, blank, fb_strobe, oc_fault, meas_valid;
    logic [PW-1:0] demag_cnt, period_cnt;

    int n_run = 0, n_fail = 0;
    string exp_tag;

    always #4 clk = ~clk;

    vsw_cycle_timer #(.PW(PW), .QW(QW), .LEB_CYC(LEB), .MIN_ON_CYC(MON),
        .MIN_DEMAG_CYC(MDM), .ZC_TMO_CYC(TMO), .PER_FLOOR_CYC(FLR)) u_dut (
        .clk(clk), .rst(rst), .en(en), .min_period(min_period), .q_dly(q_dly),
        .pk_trip(pk_trip), .oc_trip(oc_trip), .demag_end(demag_end), .zc(zc),
        .drv(drv), .blank(blank), .fb_strobe(fb_strobe), .oc_fault(oc_fault),
        .meas_valid(meas_valid), .demag_cnt(demag_cnt), .period_cnt(period_cnt));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    function automatic bit zc_pat(input int d, input int dd, input int nr);
        int k = d - dd - 1;
        if (k < 0) return 1'b1;
        if (k < 2 * H * nr) return ((k / H) % 2) == 0;
        return 1'b1;
    endfunction

    function automatic int exp_low(input int ton, input int dd, input int nr,
                                   input int qd, input int mpe);
        int x;
        for (int j = 0; j < nr; j++) begin
            x = dd + 1 + H * (2 * j + 1);
            if (ton + x + 2 + qd >= mpe) begin
                exp_tag = (j == 0) ? "R7 valley" : "R8 skip";
                return x + 2 + qd;
            end
        end
        x = (nr == 0) ? dd : dd + 1 + H * (2 * nr - 1);
        if (ton + x + 2 + TMO < mpe) begin
            exp_tag = "R10 floor";
            return mpe - ton;
        end
        exp_tag = "R9 timeout";
        return x + 2 + TMO;
    endfunction

    // Called at a negedge in the first drive-high cycle; returns at the next one.
    task automatic run_cycle(input int a, input int dd, input int nr,
                             input int qd, input int mp);
        int c = 0, d = 0, blanks = 0, fb_at = -1, fb_n = 0, bad = 0, ton, lo, mpe, el;
        min_period = PW'(mp);
        q_dly = QW'(qd);
        mpe = (mp > FLR) ? mp : FLR;
        while (drv === 1'b1 && c < 500) begin
            blanks += int'(blank);
            pk_trip = (c >= a);
            zc = 1'b1;
            demag_end = 1'b0;
            c++;
            @(negedge clk);
        end
        pk_trip = 1'b0;
        ton = c;
        while (drv === 1'b0 && d < 500) begin
            if (fb_strobe) begin fb_at = d; fb_n++; end
            if (meas_valid || blank) bad++;
            demag_end = (d == 2) || (d == dd);
            zc = zc_pat(d, dd, nr);
            d++;
            @(negedge clk);
        end
        demag_end = 1'b0;
        zc = 1'b1;
        lo = d;
        el = exp_low(ton, dd, nr, qd, mpe);
        chk(ton == ((a > MON) ? a : MON) + 1, "R4 on-time", ton, ((a > MON) ? a : MON) + 1);
        chk(blanks == LEB, "R3 blank length", blanks, LEB);
        chk(fb_at == dd + 1 && fb_n == 1, "R6 strobe cycle", fb_at, dd + 1);
        chk(bad == 0, "R11 quiet while off", bad, 0);
        chk(lo == el, exp_tag, lo, el);
        chk(ton + lo >= mpe, "R10 min period", ton + lo, mpe);
        chk(meas_valid === 1'b1, "R11 valid", int'(meas_valid), 1);
        chk(int'(period_cnt) == ton + lo, "R11 period_cnt", int'(period_cnt), ton + lo);
        chk(int'(demag_cnt) == dd + 1, "R11 demag_cnt", int'(demag_cnt), dd + 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        int ab[3], db[3], nb[3], qb[3], mb[4];
        ab = '{0, 8, 11};
        db = '{5, 8, 12};
        nb = '{0, 1, 4};
        qb = '{0, 2, 4};
        mb = '{0, 25, 40, 70};

        // R1 reset state
        repeat (3) @(negedge clk);
        chk(!drv && !blank && !fb_strobe && !oc_fault && !meas_valid, "R1 in reset",
            int'({drv, blank, fb_strobe, oc_fault, meas_valid}), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(!drv && !blank && !fb_strobe && !oc_fault && !meas_valid, "R1 after reset",
            int'({drv, blank, fb_strobe, oc_fault, meas_valid}), 0);

        en = 1'b1;
        @(negedge clk);
        chk(drv === 1'b1 && meas_valid === 1'b0, "R2 start from idle",
            int'({drv, meas_valid}), 2);

        // sweep of trip point, demag length, ring count, valley delay, min period
        foreach (ab[i]) foreach (db[j]) foreach (nb[k]) foreach (qb[m]) foreach (mb[p])
            run_cycle(ab[i], db[j], nb[k], qb[m], mb[p]);

        // R2 enable drop during the on-phase
        en = 1'b0;
        #1;
        chk(drv === 1'b0, "R2 drive off at once", int'(drv), 0);
        @(negedge clk);
        chk(drv === 1'b0 && blank === 1'b0, "R2 stays off", int'({drv, blank}), 0);
        en = 1'b1;
        @(negedge clk);
        chk(drv === 1'b1 && meas_valid === 1'b0, "R2 restart no measurement",
            int'({drv, meas_valid}), 2);
        run_cycle(0, 5, 1, 0, 0);

        // R3 blanked over-current ignored, R5 unblanked one latches
        for (int c = 0; c < 6; c++) begin
            oc_trip = (c == 1) || (c == 5);
            if (c == 2)
                chk(drv === 1'b1 && oc_fault === 1'b0, "R3 blanked oc ignored",
                    int'({drv, oc_fault}), 2);
            @(negedge clk);
        end
        oc_trip = 1'b0;
        chk(drv === 1'b0 && oc_fault === 1'b1, "R5 fault entry", int'({drv, oc_fault}), 1);
        begin
            int bad = 0;
            for (int c = 0; c < 40; c++) begin
                pk_trip = c[0];
                demag_end = c[1];
                zc = c[2];
                if (drv !== 1'b0 || oc_fault !== 1'b1) bad++;
                @(negedge clk);
            end
            chk(bad == 0, "R5 fault held", bad, 0);
        end
        pk_trip = 1'b0; demag_end = 1'b0; zc = 1'b1;
        en = 1'b0;
        @(negedge clk);
        chk(oc_fault === 1'b0, "R5 fault cleared by enable", int'(oc_fault), 0);
        en = 1'b1;
        @(negedge clk);
        chk(drv === 1'b1, "R5 restart after clear", int'(drv), 1);
        run_cycle(7, 6, 2, 1, 30);

        summary();
        $finish;
    end
endmodule